// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block times a single access to memory outside the chip. A requester hands it one transfer: an address, a read or write flag, a byte or word size and, for writes, a 16-bit value. The sequencer walks through the access state by state. The first state is the address phase, marked by an address-latch strobe. Then come an optional turnaround state, programmable wait states, the data state and an optional recovery state in which the shared lines float. At the end it returns read data together with a one-clock completion pulse.

Four configuration inputs describe the memory region being addressed:
- Multiplexed or separate address and data lines.
- An 8-bit or 16-bit data path.
- A 4-bit wait code. A larger code means fewer wait states.
- A 1-bit recovery code. A value of 1 removes the recovery state.

A 16-bit word on an 8-bit path becomes two complete access cycles.

The configuration is captured when a transfer is accepted, so the region decoder upstream may move on while the access is still running.

Top module: `xbus_cycle_seq`

## Requirements
- R1: `reqReady` is high exactly when no transfer is in progress. A request with `reqValid` high on a clock where `reqReady` is high is accepted, and `busAle` is high in the very next clock. `reqReady` stays low from then until the completion pulse has ended.
- R2: On separate address/data lines, one access cycle lasts 2 + (15 − `cfgWaitCode`) + (1 − `cfgRecovCode`) clocks. This gives 2 to 18 clocks.
- R3: On multiplexed lines, one access cycle lasts one clock longer than in R2. In the address-latch state, `busAdOe` is high and `busAdOut` carries address bits 15:0.
- R4: `busAle` is high for exactly the first clock of each access cycle and never for two clocks in a row.
- R5: `done` is high for exactly one clock, which is the final state of the last access cycle of a transfer. `reqReady` is high in the following clock.
- R6: On an 8-bit path, a word transfer runs two access cycles. The first goes to the address with bit 0 cleared and carries the low byte; the second goes to the address with bit 0 set and carries the high byte. Both use data lines 7:0. A read returns {second byte, first byte} on `rdData`. A byte transfer runs one cycle.
- R7: On a 16-bit path, every transfer is one access cycle. A word uses all 16 lines; a word's address has bit 0 cleared. A byte uses lines 7:0 at the given address and reads back as {8'h00, lines 7:0}.
- R8: During every state after the address phase up to and including the data state, a write holds `busWrN` low with `busAdOe` high and drives its data on `busAdOut`. A read holds `busRdN` low with `busAdOe` low.
- R9: Each recovery state has `busAle` low, both strobes high and `busAdOe` low. There are (1 − `cfgRecovCode`) of them per access cycle.
- R10: Configuration inputs are sampled only when a request is accepted. Changes while a transfer runs have no effect on its timing, addresses or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state per period |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Sequencer idle; request taken on this clock |
| reqAddr | input | ADDR_W | Transfer address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqWData | input | 16 | Write value (byte in bits 7:0) |
| cfgMux | input | 1 | 1 = address and data share the lines |
| cfgBus8 | input | 1 | 1 = 8-bit data path |
| cfgWaitCode | input | WAIT_W | Wait code; wait states = 15 − code |
| cfgRecovCode | input | 1 | Recovery code; recovery states = 1 − code |
| busAle | output | 1 | Address-latch strobe |
| busAddr | output | ADDR_W | Address of the current access cycle |
| busAdOut | output | 16 | Shared line drive value |
| busAdIn | input | 16 | Shared line receive value |
| busAdOe | output | 1 | Shared line output enable |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| rdData | output | 16 | Read result, valid while `done` is high |
| done | output | 1 | Transfer complete pulse |

## Verification
For a transfer accepted at edge 0, `done` is due in clock L × n. Here L is the per-cycle length from R2 or R3, and n is 1 or 2 from R6 and R7. `reqReady` is due one clock later, and `busAle` is due in clock 1 and again in clock L + 1 for a split word. The monitor samples every output on the falling edge. It counts busy clocks from the point where `reqReady` falls, so each latency is compared in the exact clock it is due. It also records the address at every latch strobe and the drive value in each strobe state. It compares all of these against the scoreboard entry when `done` appears.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int DATA_W = 16;
  localparam int LANE_W = DATA_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_TURN,
    ST_WAIT,
    ST_DATA,
    ST_RECOV
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture request fields
    logic aleOn;      // address-latch state
    logic addrOnAd;   // address on shared lines
    logic xferOn;     // read/write strobe active
    logic upperHalf;  // second cycle of a split word
    logic dataEnd;    // data state (bus sampled at its end)
    logic lastData;   // data state of final cycle
  } seqStrobe_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWord,
  input  logic              cfgMux,
  input  logic              cfgBus8,
  input  logic [WAIT_W-1:0] cfgWaitCode,
  input  logic              cfgRecovCode,
  output logic              reqReady,
  output logic              done,
  output seqStrobe_t        strobe
);

  seqState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLen;
  logic              muxR;
  logic              splitR;
  logic              recovR;
  logic              halfR;
  logic              lastSub;
  logic              finalState;

  assign lastSub    = !splitR || halfR;
  assign finalState = (state == ST_DATA && !recovR) || (state == ST_RECOV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      waitLen <= '0;
      muxR    <= 1'b0;
      splitR  <= 1'b0;
      recovR  <= 1'b0;
      halfR   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            muxR    <= cfgMux;
            splitR  <= cfgBus8 && reqWord;
            waitLen <= ~cfgWaitCode;     // inverted sense: all-ones code = no waits
            recovR  <= ~cfgRecovCode;    // inverted sense: 1 = no recovery
            halfR   <= 1'b0;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          waitCnt <= waitLen;
          if (muxR)                state <= ST_TURN;
          else if (waitLen != '0)  state <= ST_WAIT;
          else                     state <= ST_DATA;
        end
        ST_TURN: begin
          state <= (waitCnt != '0) ? ST_WAIT : ST_DATA;
        end
        ST_WAIT: begin
          waitCnt <= waitCnt - 1'b1;
          if (waitCnt == {{(WAIT_W-1){1'b0}}, 1'b1}) state <= ST_DATA;
        end
        ST_DATA, ST_RECOV: begin
          if (state == ST_DATA && recovR) begin
            state <= ST_RECOV;
          end else if (lastSub) begin
            state <= ST_IDLE;
          end else begin
            halfR <= 1'b1;
            state <= ST_ADDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load      = (state == ST_IDLE) && reqValid;
    strobe.aleOn     = (state == ST_ADDR);
    strobe.addrOnAd  = (state == ST_ADDR) && muxR;
    strobe.xferOn    = (state == ST_TURN) || (state == ST_WAIT) || (state == ST_DATA);
    strobe.upperHalf = halfR;
    strobe.dataEnd   = (state == ST_DATA);
    strobe.lastData  = (state == ST_DATA) && lastSub;
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = finalState && lastSub;

endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              cfgBus8,
  input  logic [DATA_W-1:0] busAdIn,
  output logic              busAle,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busAdOut,
  output logic              busAdOe,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] wdataR;
  logic              writeR;
  logic              wordR;
  logic              bus8R;
  logic [LANE_W-1:0] loByteR;
  logic [DATA_W-1:0] rdR;
  logic [DATA_W-1:0] writeLane;
  logic [DATA_W-1:0] assembled;
  logic              wrDrive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR   <= '0;
      wdataR  <= '0;
      writeR  <= 1'b0;
      wordR   <= 1'b0;
      bus8R   <= 1'b0;
      loByteR <= '0;
      rdR     <= '0;
    end else begin
      if (strobe.load) begin
        addrR  <= reqAddr;
        wdataR <= reqWData;
        writeR <= reqWrite;
        wordR  <= reqWord;
        bus8R  <= cfgBus8;
      end
      if (strobe.dataEnd && !strobe.upperHalf) loByteR <= busAdIn[LANE_W-1:0];
      if (strobe.lastData) rdR <= assembled;
    end
  end

  // word accesses: bit 0 selects the byte half of a split word
  assign busAddr = wordR ? {addrR[ADDR_W-1:1], strobe.upperHalf} : addrR;

  always_comb begin
    if (bus8R)
      writeLane = {{LANE_W{1'b0}},
                   (wordR && strobe.upperHalf) ? wdataR[DATA_W-1:LANE_W] : wdataR[LANE_W-1:0]};
    else if (wordR)
      writeLane = wdataR;
    else
      writeLane = {{LANE_W{1'b0}}, wdataR[LANE_W-1:0]};
  end

  always_comb begin
    if (wordR && bus8R)
      assembled = {busAdIn[LANE_W-1:0], loByteR};
    else if (wordR)
      assembled = busAdIn;
    else
      assembled = {{LANE_W{1'b0}}, busAdIn[LANE_W-1:0]};
  end

  assign wrDrive  = strobe.xferOn && writeR;
  assign busAle   = strobe.aleOn;
  assign busRdN   = !(strobe.xferOn && !writeR);
  assign busWrN   = !wrDrive;
  assign busAdOe  = strobe.addrOnAd || wrDrive;
  assign busAdOut = strobe.addrOnAd ? busAddr[DATA_W-1:0] : (wrDrive ? writeLane : '0);

  // bypass in the final data state so the result meets the done pulse
  assign rdData = strobe.lastData ? assembled : rdR;

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [15:0]       reqWData,
  input  logic              cfgMux,
  input  logic              cfgBus8,
  input  logic [WAIT_W-1:0] cfgWaitCode,
  input  logic              cfgRecovCode,
  output logic              busAle,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       busAdOut,
  input  logic [15:0]       busAdIn,
  output logic              busAdOe,
  output logic              busRdN,
  output logic              busWrN,
  output logic [15:0]       rdData,
  output logic              done
);

  seqStrobe_t strobe;

  xbus_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWord      (reqWord),
    .cfgMux       (cfgMux),
    .cfgBus8      (cfgBus8),
    .cfgWaitCode  (cfgWaitCode),
    .cfgRecovCode (cfgRecovCode),
    .reqReady     (reqReady),
    .done         (done),
    .strobe       (strobe)
  );

  xbus_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .reqWData (reqWData),
    .cfgBus8  (cfgBus8),
    .busAdIn  (busAdIn),
    .busAle   (busAle),
    .busAddr  (busAddr),
    .busAdOut (busAdOut),
    .busAdOe  (busAdOe),
    .busRdN   (busRdN),
    .busWrN   (busWrN),
    .rdData   (rdData)
  );

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWord,
  input logic              cfgMux,
  input logic              cfgBus8,
  input logic [WAIT_W-1:0] cfgWaitCode,
  input logic              cfgRecovCode,
  input logic              busAle,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busAdOut,
  input logic              busAdOe,
  input logic              done
);

  localparam int MAX_WAIT = (1 << WAIT_W) - 1;

  logic        accept;
  logic        muxL;
  logic [15:0] expLen;
  logic [1:0]  expSubs;
  logic [15:0] cycCnt;
  logic [1:0]  aleCnt;
  logic [15:0] oneLen;

  assign accept = reqValid && reqReady;
  assign oneLen = 16'((cfgMux ? 3 : 2) + (MAX_WAIT - int'(cfgWaitCode)) + (cfgRecovCode ? 0 : 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxL    <= 1'b0;
      expLen  <= '0;
      expSubs <= '0;
      cycCnt  <= '0;
      aleCnt  <= '0;
    end else if (accept) begin
      muxL    <= cfgMux;
      expSubs <= (cfgBus8 && reqWord) ? 2'd2 : 2'd1;
      expLen  <= (cfgBus8 && reqWord) ? (oneLen << 1) : oneLen;
      cycCnt  <= 16'd1;
      aleCnt  <= 2'd0;
    end else begin
      if (!reqReady) cycCnt <= cycCnt + 16'd1;
      if (busAle)    aleCnt <= aleCnt + 2'd1;
    end
  end

  p_accept_ale_r1: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busAle);

  p_busy_ale_r1: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> !reqReady);

  p_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycCnt == expLen));

  p_mux_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAle && muxL) |-> (busAdOe && busAdOut == busAddr[15:0]));

  p_ale_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> !busAle);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));

  p_sub_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (aleCnt == expSubs));

endmodule

bind xbus_cycle_seq xbus_seq_chk #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_seqChk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqWord      (reqWord),
  .cfgMux       (cfgMux),
  .cfgBus8      (cfgBus8),
  .cfgWaitCode  (cfgWaitCode),
  .cfgRecovCode (cfgRecovCode),
  .busAle       (busAle),
  .busAddr      (busAddr),
  .busAdOut     (busAdOut),
  .busAdOe      (busAdOe),
  .done         (done)
);

// File: tb/test_xbus_cycle_seq.sv
module test_xbus_cycle_seq;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic          reqWrite = 1'b0;
  logic          reqWord = 1'b0;
  logic [15:0]   reqWData = '0;
  logic          cfgMux = 1'b0;
  logic          cfgBus8 = 1'b0;
  logic [3:0]    cfgWaitCode = 4'hF;
  logic          cfgRecovCode = 1'b1;
  logic          busAle;
  logic [AW-1:0] busAddr;
  logic [15:0]   busAdOut;
  logic [15:0]   busAdIn;
  logic          busAdOe;
  logic          busRdN;
  logic          busWrN;
  logic [15:0]   rdData;
  logic          done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xbus_cycle_seq #(.ADDR_W(AW), .WAIT_W(4)) i_xbus_cycle_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWord(reqWord), .reqWData(reqWData),
    .cfgMux(cfgMux), .cfgBus8(cfgBus8), .cfgWaitCode(cfgWaitCode), .cfgRecovCode(cfgRecovCode),
    .busAle(busAle), .busAddr(busAddr), .busAdOut(busAdOut), .busAdIn(busAdIn),
    .busAdOe(busAdOe), .busRdN(busRdN), .busWrN(busWrN), .rdData(rdData), .done(done)
  );

  // memory model: lines 7:0 hold the byte at busAddr, lines 15:8 the byte at busAddr|1
  function automatic logic [7:0] byteVal(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always_comb begin
    if (!busRdN) busAdIn = {byteVal(busAddr | AW'(1)), byteVal(busAddr)};
    else         busAdIn = 16'h0BAD;
  end

  typedef struct {
    bit            isWrite;
    bit            mux;
    int            cycles;
    int            subs;
    int            recov;
    logic [AW-1:0] addr0;
    logic [AW-1:0] addr1;
    logic [15:0]   wr0;
    logic [15:0]   wr1;
    logic [15:0]   rdExp;
  } exp_t;

  exp_t expQ[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: computes expectations from the requirements and pushes them
  task automatic doXfer(input logic [AW-1:0] addr, input bit wr, input bit word,
                        input logic [15:0] wdata, input bit mux, input bit bus8,
                        input logic [3:0] wcode, input bit rcode,
                        input bit disturb, input bit waitDone);
    exp_t e;
    logic [AW-1:0] a0;
    int len;
    len = (mux ? 3 : 2) + (15 - int'(wcode)) + (rcode ? 0 : 1);
    a0  = word ? {addr[AW-1:1], 1'b0} : addr;
    e.isWrite = wr;
    e.mux     = mux;
    e.subs    = (bus8 && word) ? 2 : 1;
    e.cycles  = len * e.subs;
    e.recov   = (rcode ? 0 : 1) * e.subs;
    e.addr0   = a0;
    e.addr1   = {addr[AW-1:1], 1'b1};
    if (bus8) begin
      e.wr0 = {8'h00, wdata[7:0]};
      e.wr1 = {8'h00, wdata[15:8]};
    end else begin
      e.wr0 = word ? wdata : {8'h00, wdata[7:0]};
      e.wr1 = '0;
    end
    e.rdExp = word ? {byteVal(a0 | AW'(1)), byteVal(a0)} : {8'h00, byteVal(addr)};

    while (!reqReady) @(negedge clk);
    reqAddr = addr; reqWrite = wr; reqWord = word; reqWData = wdata;
    cfgMux = mux; cfgBus8 = bus8; cfgWaitCode = wcode; cfgRecovCode = rcode;
    reqValid = 1'b1;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    expQ.push_back(e);
    if (disturb) begin
      // R10: flip every configuration input after acceptance
      cfgMux = ~mux; cfgBus8 = ~bus8; cfgWaitCode = ~wcode; cfgRecovCode = ~rcode;
      reqAddr = ~addr; reqWData = ~wdata; reqWord = ~word;
    end
    @(negedge clk);
    check("R1", "reqReady low after accept", reqReady, 1'b0);
    check("R4", "busAle in first clock", busAle, 1'b1);
    if (waitDone) while (expQ.size() != 0) @(negedge clk);
  endtask

  // monitor
  int            cyc = 0;
  int            subIdx = 0;
  int            recCnt = 0;
  bit            prevDone = 0;
  logic [AW-1:0] seenAddr [2];
  logic [15:0]   seenWr [2];

  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (prevDone) check("R5", "reqReady after done", reqReady, 1'b1);
      if (prevDone) check("R5", "done single clock", done, 1'b0);
      prevDone = done;
      if (reqReady) begin
        cyc = 0; subIdx = 0; recCnt = 0;
      end else if (expQ.size() != 0) begin
        cyc++;
        if (busAle) begin
          if (subIdx < 2) seenAddr[subIdx] = busAddr;
          if (expQ[0].mux) begin
            check("R3", "mux address on lines", busAdOut, 32'(busAddr[15:0]));
            check("R3", "mux address enable", busAdOe, 1'b1);
          end
          subIdx++;
        end
        if (!busWrN) begin
          if (subIdx >= 1 && subIdx <= 2) seenWr[subIdx-1] = busAdOut;
          if (!busAdOe) check("R8", "write enable", busAdOe, 1'b1);
        end
        if (!busRdN && busAdOe) check("R8", "read enable", busAdOe, 1'b0);
        if (!busAle && busRdN && busWrN) begin
          recCnt++;
          if (busAdOe) check("R9", "recovery enable", busAdOe, 1'b0);
        end
        if (done) begin
          exp_t e;
          e = expQ.pop_front();
          check(e.mux ? "R3" : "R2", "latency", cyc, e.cycles);
          check("R6", "sub-cycle count", subIdx, e.subs);
          check("R9", "recovery states", recCnt, e.recov);
          check("R7", "first address", seenAddr[0], e.addr0);
          if (e.subs == 2) check("R6", "second address", seenAddr[1], e.addr1);
          if (e.isWrite) begin
            check("R8", "write data first", seenWr[0], e.wr0);
            if (e.subs == 2) check("R6", "write data second", seenWr[1], e.wr1);
          end else begin
            check("R7", "read data", rdData, e.rdExp);
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset reqReady", reqReady, 1'b1);
    check("R5", "reset done", done, 1'b0);
    check("R4", "reset busAle", busAle, 1'b0);
    check("R8", "reset strobes", {busRdN, busWrN, busAdOe}, 3'b110);

    // R2: separate lines, 16-bit word read, shortest cycle (2)
    doXfer(20'h01234, 0, 1, 16'h0, 0, 0, 4'hF, 1, 0, 1);
    // R2 R8 R9: longest separate cycle (18), word write
    doXfer(20'h0A0B6, 1, 1, 16'hBEEF, 0, 0, 4'h0, 0, 0, 1);
    // R3: multiplexed word read, 3 waits + recovery (7)
    doXfer(20'h5C3E8, 0, 1, 16'h0, 1, 0, 4'hC, 0, 0, 1);
    // R3 R7: multiplexed byte write to odd address (3)
    doXfer(20'h00777, 1, 0, 16'hA5C3, 1, 0, 4'hF, 1, 0, 1);
    // R6: 8-bit word read split into two cycles of 3
    doXfer(20'h31415, 0, 1, 16'h0, 0, 1, 4'hE, 1, 0, 1);
    // R6 R8: multiplexed 8-bit word write, two cycles of 6
    doXfer(20'h2468A, 1, 1, 16'h9E37, 1, 1, 4'hD, 0, 0, 1);
    // R6: 8-bit byte read at odd address, single cycle
    doXfer(20'h0FFF1, 0, 0, 16'h0, 0, 1, 4'hB, 1, 0, 1);
    // R7: 16-bit byte read, upper byte zero
    doXfer(20'h13579, 0, 0, 16'h0, 0, 0, 4'h7, 0, 0, 1);
    // R10: configuration flipped mid-transfer
    doXfer(20'h4F00C, 0, 1, 16'h0, 0, 1, 4'hA, 1, 1, 1);
    doXfer(20'h4F010, 1, 1, 16'h1357, 1, 0, 4'h9, 0, 1, 1);
    // R5: back-to-back requests
    doXfer(20'h00100, 0, 1, 16'h0, 0, 0, 4'hF, 1, 0, 0);
    doXfer(20'h00202, 1, 0, 16'h00C4, 0, 0, 4'hF, 1, 0, 0);
    doXfer(20'h00304, 0, 1, 16'h0, 1, 1, 4'hF, 1, 0, 1);
    // R6 R2: slowest split word (2 x 18)
    doXfer(20'hFFFFE, 0, 1, 16'h0, 0, 1, 4'h0, 0, 0, 1);

    repeat (4) @(negedge clk);
    check("R1", "idle at end", reqReady, 1'b1);
    finish_run();
  end

endmodule